// File: doc/BRIEF.md
# MDIO Command-Word Management Master

This block runs clause-22 management frames toward an Ethernet PHY. Software launches a transfer by writing one 32-bit command word. The word carries the PHY address, the register address, an operation selector and, for a write, 16 bits of data. The block then produces the management clock itself. It shifts out a full serial frame, and for a read it captures the 16 bits that the PHY returns.

The result appears in a 32-bit status word that software polls. A read-complete flag and the returned data sit in that word, next to a separate write-complete flag and a busy flag. The bidirectional data pad is split into an output, an output enable and an input. The pad cell and its pull-up sit outside the block.

The management clock is derived from the system clock by a divider. Each half period lasts `HALF_DIV` system cycles. The default of 50 gives 2.5 MHz from a 250 MHz clock.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset, `status` is all zeros and `mdc` and `mdio_oe` are low.
- R2: A command word is decoded when `cmd_wr` is high. Bit 27 requests a read and bit 26 requests a write. If both bits are set, the read is performed. A word with neither bit set starts nothing.
- R3: Every frame opens with 35 one bits, followed by the start pattern 0 and then 1.
- R4: The two opcode bits after the start pattern are 1,0 for a read and 0,1 for a write.
- R5: After the opcode, the 5-bit PHY address (command bits 25:21) is sent, then the 5-bit register address (command bits 20:16). Each address goes most significant bit first.
- R6: A write frame continues with the turnaround bits 1 then 0. It then sends the 16 data bits of command bits 15:0, most significant first, for 67 clock pulses in total. `mdio_oe` is high for every bit of the frame.
- R7: A read frame drops `mdio_oe` from the turnaround bit (the 50th bit) to the end of the frame, for 66 pulses in total. The turnaround bit is discarded. The next 16 bits are sampled as `mdc` rises, most significant first, and they appear in `status[15:0]`.
- R8: `mdc` stays low for `HALF_DIV` cycles and then high for `HALF_DIV` cycles for every bit. A frame keeps `status[31]` high for exactly bits × 2 × `HALF_DIV` cycles. `mdio_o` and `mdio_oe` change only while `mdc` is low.
- R9: `status[28]` is set when a read frame ends. It is cleared in the cycle a new read is accepted, and only then.
- R10: `status[29]` is set when a write frame's last data bit ends. It is cleared when a new write is accepted.
- R11: A command written while a frame is in progress has no effect. This includes a command written in the final cycle of the frame.
- R12: `status[31]` is high from the cycle after a command is accepted until the frame ends. While `status[31]` is low, `mdc` and `mdio_oe` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| status | output | 32 | Busy (31), write done (29), read done (28), read data (15:0) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data toward the PHY |
| mdio_oe | output | 1 | Drive enable for the data pad |
| mdio_i | input | 1 | Serial data from the pad |

## Verification
Two events can fall in the same cycle: a command strobe and the end of a running frame. The bench counts the exact busy window of a write frame. It then raises a read command in the last cycle that the write's busy flag is still high. The run passes only if that read is refused: busy drops the next cycle, the write-complete flag sets, and the earlier read flag and data stay untouched. A second contest pits an accepted command against the flag it clears. The bench launches a write right after the previous write completes and checks that the write flag reads low one cycle later.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

  localparam int PRE_BITS   = 35;
  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int HDR_BITS   = PRE_BITS + 4 + 2 * ADDR_W;   // preamble, start, opcode, addresses
  localparam int WR_BITS    = HDR_BITS + 2 + DATA_W;       // 67
  localparam int RD_BITS    = HDR_BITS + 1 + DATA_W;       // 66
  localparam int RD_RELEASE = HDR_BITS;                    // index of read turnaround bit
  localparam int IDX_W      = $clog2(WR_BITS);

  // command/status word field positions
  localparam int F_RD_GO   = 27;
  localparam int F_WR_GO   = 26;
  localparam int F_PHY_LSB = 21;
  localparam int F_REG_LSB = 16;
  localparam int F_RD_DONE = 28;
  localparam int F_WR_DONE = 29;
  localparam int F_BUSY    = 31;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } mdio_op_e;

  typedef struct packed {
    mdio_op_e            op;
    logic [ADDR_W-1:0]   phy;
    logic [ADDR_W-1:0]   regad;
    logic [DATA_W-1:0]   wdata;
  } mdio_cmd_t;

  // read has priority when both request bits are set
  function automatic mdio_cmd_t decode_cmd(input logic [31:0] w);
    mdio_cmd_t c;
    if (w[F_RD_GO])      c.op = OP_READ;
    else if (w[F_WR_GO]) c.op = OP_WRITE;
    else                 c.op = OP_IDLE;
    c.phy   = w[F_PHY_LSB +: ADDR_W];
    c.regad = w[F_REG_LSB +: ADDR_W];
    c.wdata = w[DATA_W-1:0];
    return c;
  endfunction

  // full frame, first bit on the wire in the MSB
  function automatic logic [WR_BITS-1:0] build_frame(input mdio_cmd_t c);
    logic [1:0]        opc;
    logic [DATA_W+1:0] tail;
    opc  = (c.op == OP_READ) ? 2'b10 : 2'b01;
    tail = (c.op == OP_READ) ? '1 : {2'b10, c.wdata};
    return {{PRE_BITS{1'b1}}, 2'b01, opc, c.phy, c.regad, tail};
  endfunction

  function automatic logic [IDX_W-1:0] frame_last(input mdio_op_e op);
    return (op == OP_READ) ? IDX_W'(RD_BITS - 1) : IDX_W'(WR_BITS - 1);
  endfunction

  function automatic logic [31:0] pack_status(input logic busy, input logic wr_done,
                                              input logic rd_done,
                                              input logic [DATA_W-1:0] rd_data);
    logic [31:0] s;
    s            = '0;
    s[F_BUSY]    = busy;
    s[F_WR_DONE] = wr_done;
    s[F_RD_DONE] = rd_done;
    s[DATA_W-1:0] = rd_data;
    return s;
  endfunction

endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer
  import mdio_cmd_pkg::*;
#(
  parameter int HALF_DIV = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] last_idx,
  output logic             busy,
  output logic             mdc,
  output logic [IDX_W-1:0] bit_idx,
  output logic             rise_en,
  output logic             end_en
);

  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_DIV - 1);

  logic             busy_q;
  logic             ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_q;
  logic             tick;
  logic             fall_en;

  assign tick    = busy_q && (cnt_q == CNT_TOP);
  assign rise_en = tick && !ph_q;
  assign fall_en = tick && ph_q;
  assign end_en  = fall_en && (idx_q == last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      ph_q   <= 1'b0;
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= last_idx;
    end else if (busy_q) begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (rise_en) ph_q <= 1'b1;
      if (fall_en) begin
        ph_q <= 1'b0;
        if (end_en) busy_q <= 1'b0;
        else        idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign busy    = busy_q;
  assign mdc     = ph_q;
  assign bit_idx = idx_q;

endmodule

// File: rtl/mdio_frame_unit.sv
module mdio_frame_unit
  import mdio_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  mdio_cmd_t          cmd,
  input  logic               busy,
  input  logic [IDX_W-1:0]   bit_idx,
  input  logic               rise_en,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  rd_word,
  output logic [WR_BITS-1:0] frame_bits
);

  logic [WR_BITS-1:0] frame_q;
  logic               is_rd_q;
  logic [DATA_W-1:0]  rd_sh_q;
  logic               drive_phase;
  logic               sample_en;
  logic               cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      is_rd_q <= 1'b0;
    end else if (load) begin
      frame_q <= build_frame(cmd);
      is_rd_q <= (cmd.op == OP_READ);
    end
  end

  assign cur_bit     = frame_q[IDX_W'(WR_BITS - 1) - bit_idx];
  assign drive_phase = !is_rd_q || (bit_idx < IDX_W'(RD_RELEASE));
  assign mdio_oe     = busy && drive_phase;
  assign mdio_o      = busy && cur_bit;

  // data bits follow the single discarded turnaround bit
  assign sample_en = rise_en && is_rd_q && (bit_idx > IDX_W'(RD_RELEASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_sh_q <= '0;
    else if (load)      rd_sh_q <= '0;
    else if (sample_en) rd_sh_q <= {rd_sh_q[DATA_W-2:0], mdio_i};
  end

  assign rd_word    = rd_sh_q;
  assign frame_bits = frame_q;

endmodule

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
  import mdio_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [31:0]       cmd_wdata,
  input  logic              busy,
  input  logic              end_en,
  input  logic [DATA_W-1:0] rd_word,
  output logic              accept,
  output mdio_cmd_t         cmd,
  output logic [31:0]       status
);

  mdio_op_e          op_q;
  logic              rd_done_q;
  logic              wr_done_q;
  logic [DATA_W-1:0] rd_data_q;

  assign cmd    = decode_cmd(cmd_wdata);
  assign accept = cmd_wr && !busy && (cmd.op != OP_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_IDLE;
      rd_done_q <= 1'b0;
      wr_done_q <= 1'b0;
      rd_data_q <= '0;
    end else begin
      if (accept) begin
        op_q <= cmd.op;
        if (cmd.op == OP_READ) rd_done_q <= 1'b0;
        else                   wr_done_q <= 1'b0;
      end else if (end_en) begin
        if (op_q == OP_READ) begin
          rd_done_q <= 1'b1;
          rd_data_q <= rd_word;
        end else begin
          wr_done_q <= 1'b1;
        end
      end
    end
  end

  assign status = pack_status(busy, wr_done_q, rd_done_q, rd_data_q);

endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
  import mdio_cmd_pkg::*;
#(
  parameter int HALF_DIV = 50  // 250 MHz / (2*50) = 2.5 MHz
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  output logic [31:0] status,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  // internal events, named for the checker
  logic               accept;
  logic               busy;
  logic               rise_en;
  logic               end_en;
  logic [IDX_W-1:0]   bit_idx;
  logic [DATA_W-1:0]  rd_word;
  logic [WR_BITS-1:0] frame_bits;
  mdio_cmd_t          cmd;

  mdio_cmd_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_wdata (cmd_wdata),
    .busy      (busy),
    .end_en    (end_en),
    .rd_word   (rd_word),
    .accept    (accept),
    .cmd       (cmd),
    .status    (status)
  );

  mdio_bit_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .last_idx (frame_last(cmd.op)),
    .busy     (busy),
    .mdc      (mdc),
    .bit_idx  (bit_idx),
    .rise_en  (rise_en),
    .end_en   (end_en)
  );

  mdio_frame_unit u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .cmd        (cmd),
    .busy       (busy),
    .bit_idx    (bit_idx),
    .rise_en    (rise_en),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe),
    .rd_word    (rd_word),
    .frame_bits (frame_bits)
  );

endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk
  import mdio_cmd_pkg::*;
#(
  parameter int HALF_DIV = 50
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_wr,
  input logic               rd_go,
  input logic               wr_go,
  input logic               busy,
  input logic               rd_done,
  input logic               wr_done,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe,
  input logic [WR_BITS-1:0] frame_bits
);

  localparam int GW = $clog2(HALF_DIV + 2) + 1;

  logic          mdc_q;
  logic          busy_q;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q  <= 1'b0;
      busy_q <= 1'b0;
      gap    <= '0;
    end else begin
      mdc_q  <= mdc;
      busy_q <= busy;
      if ((mdc != mdc_q) || (busy && !busy_q)) gap <= '0;
      else if (!(&gap))                        gap <= gap + 1'b1;
    end
  end

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc != mdc_q) |-> (gap == GW'(HALF_DIV - 1))); // R8
  AST_PAD_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && mdc_q) |-> ($stable(mdio_o) && $stable(mdio_oe))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe)); // R12
  AST_RD_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && rd_go) |=> (busy && !rd_done)); // R9
  AST_WR_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !rd_go && wr_go) |=> (busy && !wr_done)); // R10
  AST_END_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (rd_done || wr_done)); // R9
  AST_FRAME_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_q) |-> $stable(frame_bits)); // R11
  AST_EMPTY_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !rd_go && !wr_go) |=> !busy); // R2

endmodule

bind mdio_cmd_master mdio_cmd_master_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_wr     (cmd_wr),
  .rd_go      (cmd_wdata[27]),
  .wr_go      (cmd_wdata[26]),
  .busy       (status[31]),
  .rd_done    (status[28]),
  .wr_done    (status[29]),
  .mdc        (mdc),
  .mdio_o     (mdio_o),
  .mdio_oe    (mdio_oe),
  .frame_bits (frame_bits)
);

// File: tb/mdio_cmd_master_test.sv
module mdio_cmd_master_test;

  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        mdio_i = 1'b1;
  wire  [31:0] status;
  wire         mdc, mdio_o, mdio_oe;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          cap_o [0:79];
  bit          cap_oe[0:79];
  int          cap_n = 0;
  logic [15:0] phy_val = '0;
  int          busy_cyc;

  always #2 clk = ~clk;

  mdio_cmd_master #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .status(status), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY side: record each bit at the clock rise
  initial forever begin
    @(posedge mdc);
    if (cap_n < 80) begin
      cap_o[cap_n]  = mdio_o;
      cap_oe[cap_n] = mdio_oe;
    end
    cap_n++;
  end

  // PHY side: present read data after the falling edge
  initial forever begin
    @(negedge mdc);
    if (cap_n >= 50 && cap_n <= 65) mdio_i = phy_val[65 - cap_n];
    else                            mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit rd, bit wr, logic [4:0] pa, logic [4:0] ra,
                                     logic [15:0] d);
    return {4'b0000, rd, wr, pa, ra, d};
  endfunction

  function automatic bit exp_bit(int i, bit rd, logic [4:0] pa, logic [4:0] ra,
                                 logic [15:0] d);
    if (i < 35)  return 1'b1;
    if (i == 35) return 1'b0;
    if (i == 36) return 1'b1;
    if (i == 37) return rd;
    if (i == 38) return !rd;
    if (i < 44)  return pa[43 - i];
    if (i < 49)  return ra[48 - i];
    if (i == 49) return 1'b1;
    if (i == 50) return 1'b0;
    return d[66 - i];
  endfunction

  function automatic int seg_bad(int lo, int hi, bit rd, logic [4:0] pa,
                                 logic [4:0] ra, logic [15:0] d);
    int n = 0;
    for (int i = lo; i <= hi; i++)
      if (cap_o[i] != exp_bit(i, rd, pa, ra, d) || cap_oe[i] != 1'b1) n++;
    return n;
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    cap_n     = 0;
    cmd_wr    = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_wr    = 1'b0;
  endtask

  task automatic poke(input logic [31:0] w);
    cmd_wr    = 1'b1;
    cmd_wdata = w;
    @(negedge clk);
    cmd_wr    = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    busy_cyc = status[31] ? 1 : 0;
    while (status[31] && guard < 6000) begin
      @(negedge clk);
      guard++;
      if (status[31]) busy_cyc++;
    end
  endtask

  task automatic t_reset();
    check(status == 32'h0, "R1", "status after reset", status, 0);
    check(mdc == 1'b0, "R1", "mdc after reset", mdc, 0);
    check(mdio_oe == 1'b0, "R1", "oe after reset", mdio_oe, 0);
  endtask

  task automatic t_none();
    issue(mk(0, 0, 5'h03, 5'h04, 16'h1234));
    check(status[31] == 1'b0, "R2", "no busy without request bit", status[31], 0);
    repeat (4 * HALF) @(negedge clk);
    check(cap_n == 0, "R2", "no pulses without request bit", cap_n, 0);
  endtask

  task automatic t_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    issue(mk(0, 1, pa, ra, d));
    check(status[31] == 1'b1, "R12", "busy after write accept", status[31], 1);
    check(status[29] == 1'b0, "R10", "write flag cleared at accept", status[29], 0);
    wait_idle();
    check(cap_n == 67, "R6", "write pulse count", cap_n, 67);
    check(busy_cyc == 67 * 2 * HALF, "R8", "write busy cycles", busy_cyc, 67 * 2 * HALF);
    check(seg_bad(0, 36, 0, pa, ra, d) == 0, "R3", "preamble and start", seg_bad(0, 36, 0, pa, ra, d), 0);
    check(seg_bad(37, 38, 0, pa, ra, d) == 0, "R4", "write opcode", seg_bad(37, 38, 0, pa, ra, d), 0);
    check(seg_bad(39, 48, 0, pa, ra, d) == 0, "R5", "addresses", seg_bad(39, 48, 0, pa, ra, d), 0);
    check(seg_bad(49, 66, 0, pa, ra, d) == 0, "R6", "turnaround and data", seg_bad(49, 66, 0, pa, ra, d), 0);
    check(status[29] == 1'b1, "R10", "write flag at end", status[29], 1);
  endtask

  task automatic t_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] v);
    int rel = 0;
    phy_val = v;
    issue(mk(1, 0, pa, ra, 16'h0));
    check(status[31] && !status[28], "R9", "busy, read flag cleared at accept", status[31:28], 4'h8);
    wait_idle();
    check(cap_n == 66, "R7", "read pulse count", cap_n, 66);
    check(busy_cyc == 66 * 2 * HALF, "R8", "read busy cycles", busy_cyc, 66 * 2 * HALF);
    check(seg_bad(0, 36, 1, pa, ra, 16'h0) == 0, "R3", "read preamble and start", seg_bad(0, 36, 1, pa, ra, 16'h0), 0);
    check(seg_bad(37, 38, 1, pa, ra, 16'h0) == 0, "R4", "read opcode", seg_bad(37, 38, 1, pa, ra, 16'h0), 0);
    check(seg_bad(39, 48, 1, pa, ra, 16'h0) == 0, "R5", "read addresses", seg_bad(39, 48, 1, pa, ra, 16'h0), 0);
    for (int i = 49; i <= 65; i++) if (cap_oe[i] == 1'b0) rel++;
    check(rel == 17, "R7", "pad released bits", rel, 17);
    check(status[28] == 1'b1, "R9", "read flag at end", status[28], 1);
    check(status[15:0] == v, "R7", "read data", status[15:0], v);
  endtask

  task automatic t_both();
    phy_val = 16'h5A3C;
    issue(mk(1, 1, 5'h1F, 5'h00, 16'hFFFF));
    wait_idle();
    check(cap_n == 66, "R2", "both bits give read frame", cap_n, 66);
    check(status[15:0] == 16'h5A3C, "R2", "both bits read data", status[15:0], 16'h5A3C);
  endtask

  task automatic t_busy_ignore();
    phy_val = 16'hC001;
    issue(mk(1, 0, 5'h02, 5'h11, 16'h0));
    repeat (20) @(negedge clk);
    poke(mk(0, 1, 5'h1C, 5'h07, 16'hBEEF));
    wait_idle();
    check(cap_n == 66, "R11", "frame not replaced", cap_n, 66);
    check(status[29] == 1'b0, "R11", "no write performed", status[29], 0);
    check(status[15:0] == 16'hC001, "R11", "read data intact", status[15:0], 16'hC001);
  endtask

  task automatic t_edge();
    int n = 67 * 2 * HALF;
    issue(mk(0, 1, 5'h0A, 5'h15, 16'h8001));
    repeat (n - 1) @(negedge clk);
    check(status[31] == 1'b1, "R11", "still busy in last cycle", status[31], 1);
    poke(mk(1, 0, 5'h01, 5'h01, 16'h0));
    check(status[31] == 1'b0, "R11", "command on last cycle refused", status[31], 0);
    check(status[29] == 1'b1, "R10", "write flag at end", status[29], 1);
    check(status[28] == 1'b1, "R11", "read flag not cleared", status[28], 1);
    repeat (3 * HALF) @(negedge clk);
    check(status[31] == 1'b0, "R11", "no frame started", status[31], 0);
  endtask

  task automatic t_b2b();
    issue(mk(0, 1, 5'h05, 5'h06, 16'h00FF));
    wait_idle();
    check(status[29] == 1'b1, "R10", "first write done", status[29], 1);
    issue(mk(0, 1, 5'h19, 5'h0C, 16'hF00D));
    check(status[29] == 1'b0, "R10", "second write clears flag", status[29], 0);
    wait_idle();
    check(seg_bad(39, 66, 0, 5'h19, 5'h0C, 16'hF00D) == 0, "R6", "second write frame",
          seg_bad(39, 66, 0, 5'h19, 5'h0C, 16'hF00D), 0);
    check(status[28] == 1'b1, "R9", "read flag kept by writes", status[28], 1);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_none();
    t_read(5'h01, 5'h03, 16'hA5F0);
    t_busy_ignore();
    t_both();
    t_write(5'h15, 5'h0A, 16'h8C41);
    t_write(5'h00, 5'h1F, 16'h0000);
    t_edge();
    t_b2b();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule